// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This unit collects completion and error events from the channel engines of a multi-channel DMA controller, records them per channel as status flags, and drives the interrupt request lines toward the processor. Each channel has a six-bit enable mask. The event-drop condition is always recorded. Each channel also carries a sync-active indication that mirrors a level from its engine.

Software reaches the unit through a small 16-bit register port with separate read and write strobes. Reading a channel's status returns its flags and clears every flag except sync-active. A mode bit selects one of two mappings. The compatibility mapping is the reset default. It exposes 9 channels and drives 6 lines. Channels 0-2 are paired with channels 6-8, so each pair shares one line and one status read. The wide mapping exposes all 16 channels, and each channel has its own line.

Top module: `dmairq_status_unit`

## Requirements
- R1: Flag bits are: bit0 timeout, bit1 event drop, bit2 half frame, bit3 end of frame, bit4 last frame, bit5 end of block, bit6 sync-active. An event pulse on an exposed channel sets flag bits 0, 2, 3, 4 and 5 only where the channel's mask bit at the same position is 1.
- R2: An event-drop pulse (bit1) sets the drop flag whatever the mask holds.
- R3: A status read returns the flags. On the following edge, bits 5:0 clear. Bit6 follows the channel's sync input one cycle late and reads do not affect it.
- R4: An event that arrives in the same cycle as a clearing read of its channel is kept after that read.
- R5: In compatibility mapping, a status read of channel c (0-2 paired with c+6, and 6-8 paired with c-6) ORs the partner's bits 5:0 into bits 11:6 of the result. The same read clears the partner's bits 5:0 but leaves the partner's bit6.
- R6: In compatibility mapping, only lines 0-5 are driven. Line i is high when channel i has any nonzero status, or when i<3 and channel i+6 has any nonzero status.
- R7: In wide mapping, line c is high exactly when channel c has nonzero status. Reads do not merge or clear partner channels.
- R8: After reset, all masks read 0x0003, all status reads 0, all lines are low and compatibility mapping is selected.
- R9: In compatibility mapping, channels 9-15 record no flags, read status 0 and keep their lines low.
- R10: A line falls in the cycle after a status read that leaves every channel feeding that line with zero status.
- R11: Address bits [5:4] pick the register group: 0 is status, 1 is mask, 2 is control. Bits [3:0] give the channel. The mask uses bits 5:0 and can be read and written. Control bit0 = 1 selects wide mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 96 | Per-channel event pulses, 6 bits per channel, channel c at [6c+5:6c] |
| sync_i | input | 16 | Per-channel sync-active level |
| bus_addr_i | input | 6 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 16 | Interrupt request lines |

## Verification
The bench first drives every event bit into a channel that still has its reset mask, then into a channel with its mask cleared. This separates mask-gated flags from the always-recorded drop flag. Paired traffic on a high-numbered partner channel, with and without its sync level, shows whether the merged read places the partner bits at 11:6, clears them, and spares the partner's sync bit. A read that collides with a new event, together with traffic on channels 9-15 in both mappings, separates lost events and wrongly exposed channels from correct behaviour. Checking the line after each read catches lines that stay high or fall too early.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int FLAG_W = 6;
  localparam int STAT_W = 7;
  localparam int F_TMO  = 0;
  localparam int F_DROP = 1;
  localparam int F_HALF = 2;
  localparam int F_EOF  = 3;
  localparam int F_LAST = 4;
  localparam int F_EOB  = 5;
  localparam int F_SYNC = 6;
  localparam logic [FLAG_W-1:0] MASK_RST = 6'h03;

  typedef enum logic [1:0] {
    RG_STAT = 2'd0,
    RG_MASK = 2'd1,
    RG_CTRL = 2'd2,
    RG_NONE = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/dmairq_chan_stat.sv
module dmairq_chan_stat
  import dmairq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expose_i,
  input  logic [FLAG_W-1:0] evt_i,
  input  logic              sync_i,
  input  logic              mask_we_i,
  input  logic [FLAG_W-1:0] mask_wd_i,
  input  logic              clr_i,
  output logic [FLAG_W-1:0] mask_o,
  output logic [STAT_W-1:0] stat_o
);
  logic [FLAG_W-1:0] mask_q, mask_d;
  logic [FLAG_W-1:0] flag_q, flag_d;
  logic              sync_q, sync_d;
  logic [FLAG_W-1:0] arm, hit;
  logic              flag_en;

  // next state
  always_comb begin
    arm         = mask_q;
    arm[F_DROP] = 1'b1;
    hit         = expose_i ? (evt_i & arm) : '0;
    mask_d      = mask_wd_i;
    sync_d      = expose_i & sync_i;
    flag_en     = clr_i | (|hit) | ~expose_i;
    if (!expose_i)  flag_d = '0;
    else if (clr_i) flag_d = hit;
    else            flag_d = flag_q | hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      flag_q <= '0;
      sync_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_d;
      if (flag_en)   flag_q <= flag_d;
      sync_q <= sync_d;
    end
  end

  assign mask_o = mask_q;
  assign stat_o = {sync_q, flag_q};

  // R2
  drop_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expose_i && evt_i[F_DROP]) |=> stat_o[F_DROP]);
  // R1
  eob_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[F_EOB] && !flag_q[F_EOB]) |=> !flag_q[F_EOB]);
  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> flag_q == '0);
  // R4
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && expose_i && evt_i[F_DROP]) |=> flag_q[F_DROP]);
endmodule

// File: rtl/dmairq_line_map.sv
module dmairq_line_map
  import dmairq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int LEG_PAIRS = 3,
  parameter int PAIR_OFS  = 6,
  parameter int LEG_LINES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_i,
  input  logic [STAT_W-1:0] stat_i [NUM_CH],
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] any_set;
  logic [NUM_CH-1:0] leg_line;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_line
    assign any_set[c] = |stat_i[c];
    if (c < LEG_PAIRS && (c + PAIR_OFS) < NUM_CH) begin : g_pair
      assign leg_line[c] = any_set[c] | any_set[c+PAIR_OFS];
    end else if (c < LEG_LINES) begin : g_single
      assign leg_line[c] = any_set[c];
    end else begin : g_off
      assign leg_line[c] = 1'b0;
    end
    assign irq_o[c] = ext_i ? any_set[c] : leg_line[c];
  end

  // R6
  leg_upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_i |-> (irq_o >> LEG_LINES) == '0);
  // R7
  ext_own_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_i && stat_i[PAIR_OFS] != '0) |-> irq_o[PAIR_OFS]);
endmodule

// File: rtl/dmairq_regif.sv
module dmairq_regif
  import dmairq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int LEG_CH    = 9,
  parameter int LEG_PAIRS = 3,
  parameter int PAIR_OFS  = 6,
  parameter int DATA_W    = 16,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int ADDR_W   = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] stat_i [NUM_CH],
  input  logic [FLAG_W-1:0] mask_i [NUM_CH],
  output logic [DATA_W-1:0] rdata_o,
  output logic              ext_o,
  output logic [NUM_CH-1:0] expose_o,
  output logic [NUM_CH-1:0] clr_o,
  output logic [NUM_CH-1:0] mask_we_o,
  output logic [FLAG_W-1:0] mask_wd_o
);
  localparam logic [CH_W-1:0] OFS_L = CH_W'(PAIR_OFS);
  localparam logic [CH_W-1:0] LP_L  = CH_W'(LEG_PAIRS);

  reg_grp_e        grp;
  logic [CH_W-1:0] ch;
  logic [CH_W-1:0] sib;
  logic            has_sib;
  logic            ext_q, ext_d, ext_en;

  assign grp = reg_grp_e'(addr_i[ADDR_W-1:CH_W]);
  assign ch  = addr_i[CH_W-1:0];

  // partner selection in compatibility mapping
  always_comb begin
    has_sib = 1'b0;
    sib     = ch;
    if (!ext_q) begin
      if (ch < LP_L) begin
        has_sib = 1'b1;
        sib     = ch + OFS_L;
      end else if (ch >= OFS_L && ch < OFS_L + LP_L) begin
        has_sib = 1'b1;
        sib     = ch - OFS_L;
      end
    end
  end

  // read mux and strobes
  always_comb begin
    rdata_o   = '0;
    clr_o     = '0;
    mask_we_o = '0;
    mask_wd_o = wdata_i[FLAG_W-1:0];
    ext_en    = 1'b0;
    ext_d     = wdata_i[0];
    unique case (grp)
      RG_STAT: begin
        rdata_o[STAT_W-1:0] = stat_i[ch];
        clr_o[ch]           = rd_i;
        if (has_sib) begin
          rdata_o[2*FLAG_W-1:FLAG_W] = rdata_o[2*FLAG_W-1:FLAG_W]
                                     | stat_i[sib][FLAG_W-1:0];
          clr_o[sib] = rd_i;
        end
      end
      RG_MASK: begin
        rdata_o[FLAG_W-1:0] = mask_i[ch];
        mask_we_o[ch]       = wr_i;
      end
      RG_CTRL: begin
        rdata_o[0] = ext_q;
        ext_en     = wr_i;
      end
      default: rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ext_q <= 1'b0;
    else if (ext_en) ext_q <= ext_d;
  end

  assign ext_o = ext_q;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_expose
    if (c < LEG_CH) begin : g_always
      assign expose_o[c] = 1'b1;
    end else begin : g_wide
      assign expose_o[c] = ext_q;
    end
  end

  // R5
  pair_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && grp == RG_STAT && !ext_q && ch < LP_L) |-> $countones(clr_o) == 2);
  // R11
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && grp == RG_CTRL) |=> ext_o == $past(wdata_i[0]));
  // R7
  wide_single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q) |-> $onehot0(clr_o));
endmodule

// File: rtl/dmairq_status_unit.sv
module dmairq_status_unit
  import dmairq_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int LEG_CH    = 9,
  parameter int LEG_PAIRS = 3,
  parameter int PAIR_OFS  = 6,
  parameter int LEG_LINES = 6,
  parameter int DATA_W    = 16,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int ADDR_W   = CH_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*FLAG_W-1:0] evt_i,
  input  logic [NUM_CH-1:0]        sync_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic                     bus_wr_i,
  input  logic                     bus_rd_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  output logic [NUM_CH-1:0]        irq_o
);
  logic [STAT_W-1:0] stat [NUM_CH];
  logic [FLAG_W-1:0] mask [NUM_CH];
  logic [NUM_CH-1:0] expose, clr, mask_we;
  logic [FLAG_W-1:0] mask_wd;
  logic              ext;

  dmairq_regif #(
    .NUM_CH(NUM_CH), .LEG_CH(LEG_CH), .LEG_PAIRS(LEG_PAIRS),
    .PAIR_OFS(PAIR_OFS), .DATA_W(DATA_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .rd_i(bus_rd_i), .wdata_i(bus_wdata_i), .stat_i(stat), .mask_i(mask),
    .rdata_o(bus_rdata_o), .ext_o(ext), .expose_o(expose), .clr_o(clr),
    .mask_we_o(mask_we), .mask_wd_o(mask_wd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmairq_chan_stat u_chan (
      .clk(clk), .rst_n(rst_n), .expose_i(expose[c]),
      .evt_i(evt_i[c*FLAG_W +: FLAG_W]), .sync_i(sync_i[c]),
      .mask_we_i(mask_we[c]), .mask_wd_i(mask_wd), .clr_i(clr[c]),
      .mask_o(mask[c]), .stat_o(stat[c])
    );
  end

  dmairq_line_map #(
    .NUM_CH(NUM_CH), .LEG_PAIRS(LEG_PAIRS), .PAIR_OFS(PAIR_OFS),
    .LEG_LINES(LEG_LINES)
  ) u_lines (
    .clk(clk), .rst_n(rst_n), .ext_i(ext), .stat_i(stat), .irq_o(irq_o)
  );

  // R10
  wide_line_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext && bus_rd_i && bus_addr_i[ADDR_W-1:CH_W] == RG_STAT
     && evt_i == '0 && sync_i == '0) |=> !irq_o[$past(bus_addr_i[CH_W-1:0])]);
  // R9
  leg_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext |-> (irq_o >> LEG_LINES) == '0);
endmodule

// File: tb/dmairq_status_unit_tb.sv
module dmairq_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] evt_i = '0;
  logic [15:0] sync_i = '0;
  logic [5:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [15:0] irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dmairq_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sync_i(sync_i),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic pulse(input int ch, input logic [5:0] bits);
    @(negedge clk);
    evt_i[ch*6 +: 6] = bits;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R8 lines", irq_o, 16'h0000);
    for (int c = 0; c < 16; c++) begin
      rd(6'(16 + c), d); chk("R8 mask", d, 16'h0003);
      rd(6'(c), d);      chk("R8 status", d, 16'h0000);
    end
    rd(6'h20, d); chk("R8 mode", d, 16'h0000);
  endtask

  task automatic t_mask_gate();
    logic [15:0] d;
    pulse(3, 6'h3F);
    chk("R1 line3", {15'b0, irq_o[3]}, 16'h0001);
    rd(6'd3, d); chk("R1 R3 gated flags", d, 16'h0003);
    chk("R10 line3 low", {15'b0, irq_o[3]}, 16'h0000);
    rd(6'd3, d); chk("R3 cleared", d, 16'h0000);
  endtask

  task automatic t_drop();
    logic [15:0] d;
    wr(6'd20, 16'h0000);
    rd(6'd20, d); chk("R11 mask readback", d, 16'h0000);
    pulse(4, 6'h3F);
    rd(6'd4, d); chk("R2 drop ignores mask", d, 16'h0002);
    wr(6'd20, 16'h0003);
  endtask

  task automatic t_sync();
    logic [15:0] d;
    @(negedge clk); sync_i[4] = 1'b1;
    @(negedge clk);
    chk("R6 sync drives line", {15'b0, irq_o[4]}, 16'h0001);
    rd(6'd4, d); chk("R3 sync read", d, 16'h0040);
    rd(6'd4, d); chk("R3 sync survives", d, 16'h0040);
    @(negedge clk); sync_i[4] = 1'b0;
    @(negedge clk);
    rd(6'd4, d); chk("R3 sync follows", d, 16'h0000);
  endtask

  task automatic t_pair();
    logic [15:0] d;
    wr(6'd23, 16'h003F);
    pulse(7, 6'h24);
    chk("R6 shared line", irq_o, 16'h0002);
    rd(6'd1, d); chk("R5 merged read", d, 16'h0900);
    chk("R10 shared line low", irq_o, 16'h0000);
    rd(6'd7, d); chk("R5 partner cleared", d, 16'h0000);
    @(negedge clk); sync_i[7] = 1'b1;
    pulse(7, 6'h01);
    rd(6'd1, d); chk("R5 merged timeout", d, 16'h0040);
    chk("R6 sync keeps shared line", {15'b0, irq_o[1]}, 16'h0001);
    rd(6'd7, d); chk("R5 partner sync kept", d, 16'h0040);
    @(negedge clk); sync_i[7] = 1'b0;
    @(negedge clk);
    chk("R6 line low", irq_o, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    pulse(3, 6'h02);
    @(negedge clk);
    bus_addr_i = 6'd3; bus_rd_i = 1'b1; evt_i[3*6 +: 6] = 6'h01;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_rd_i = 1'b0; evt_i = '0;
    chk("R4 read value", d, 16'h0002);
    rd(6'd3, d); chk("R4 event kept", d, 16'h0001);
  endtask

  task automatic t_hidden();
    logic [15:0] d;
    pulse(10, 6'h3F);
    chk("R9 lines", irq_o, 16'h0000);
    rd(6'd10, d); chk("R9 status", d, 16'h0000);
  endtask

  task automatic t_wide();
    logic [15:0] d;
    wr(6'h20, 16'h0001);
    rd(6'h20, d); chk("R11 mode readback", d, 16'h0001);
    pulse(10, 6'h02);
    chk("R7 own line", irq_o, 16'h0400);
    rd(6'd10, d); chk("R7 read", d, 16'h0002);
    chk("R10 wide line low", irq_o, 16'h0000);
    pulse(7, 6'h02);
    chk("R7 no sharing", irq_o, 16'h0080);
    rd(6'd1, d); chk("R7 no merge", d, 16'h0000);
    rd(6'd7, d); chk("R7 partner untouched", d, 16'h0002);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask_gate();
    t_drop();
    t_sync();
    t_pair();
    t_collide();
    t_hidden();
    t_wide();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule